// File: doc/BRIEF.md
# Serial Line-Count Decoder and Video Format Classifier

This block sits next to an analog sync separator whose format output sends, once per field, the number of lines in that field as an 11-bit serial word. One bit is sent per line, most significant bit first. The block watches the active-low horizontal and vertical sync lines and finds the lines that carry the word. It reads each bit halfway through its line, away from the edges where the data line may be switching. It then reports the received count, a format code, a field indication and a composite-video flag.

The mid-line sampling point comes from measuring the line period. A counter runs between horizontal sync falling edges. At each falling edge, half of the last measured period is loaded into a countdown, and the bit is taken when that countdown expires. After the eleventh bit the count is matched against the nominal counts of seven broadcast formats, with a tolerance on each side. The format code moves to a new value only when two fields in a row decode to that same value. The composite flag is the third bit sent. It can directly enable a chroma filter, because that bit is set only for standard-definition composite formats.

Top module: `lcount_decoder`

## Requirements
- R1: Bit capture starts at the 3rd falling edge of `hsync_n` counted after a falling edge of `vsync_n`. One bit is taken per line over the next 11 lines, and the first bit taken is bit 10 (MSB) of the count. A new `vsync_n` falling edge abandons a capture that is in progress and starts counting again.
- R2: Each bit is sampled once per line, about half a measured line period after the `hsync_n` falling edge. Values on `vf_data` in the first and last sixth of the line have no effect.
- R3: After the 11th bit, `line_count` holds the received word and `count_valid` is high for exactly one clock. `count_valid` pulses once per complete capture.
- R4: `fmt_code` uses these encodings, each matching a count within ±2 lines of its nominal value(s): 1 = 525-line interlaced (259/260), 2 = 625-line interlaced (309/310), 3 = 480-line progressive (522), 4 = 576-line progressive (622), 5 = 720-line progressive (747), 6 = 1080-line interlaced (559/560), 7 = 1080-line progressive (1122).
- R5: A count inside none of those windows decodes as code 0 (unknown).
- R6: `field_one` is updated with every `count_valid`. For an interlaced format it is 1 when the count is at or above the larger nominal value (field 1) and 0 otherwise (field 2). For progressive or unknown counts it is 1.
- R7: `composite` takes bit 8 of the received word (the third bit sent) at every `count_valid`. That bit is 1 only for the two standard-definition interlaced formats.
- R8: `fmt_code` changes only at a `count_valid`, and only to a code that was also decoded from the previous complete field. Otherwise it keeps its value.
- R9: While `rst` is high, `line_count`, `fmt_code`, `field_one`, `count_valid` and `composite` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_n | input | 1 | Active-low horizontal sync; its falling edge clocks the serial data |
| vsync_n | input | 1 | Active-low vertical sync; its falling edge marks the start of a field |
| vf_data | input | 1 | Serial line-count data |
| line_count | output | 11 | Last received line count |
| fmt_code | output | 3 | Confirmed format code (0 = unknown) |
| field_one | output | 1 | 1 for field 1 or progressive, 0 for field 2 |
| count_valid | output | 1 | One-clock strobe when a new count is presented |
| composite | output | 1 | Standard-definition composite-video flag |

## Verification
The embedded properties check, on every clock, that the mid-line sample fires at most once per line, that the received-bit counter never goes past eleven, that `count_valid` is a single-cycle pulse, that `fmt_code` holds between strobes, and that a newly confirmed standard-definition code comes with the composite flag set. The properties cannot show the mapping from counts to codes, the field polarity, the bit order, the start at the third edge, or that a capture cut short by a new vertical sync is thrown away. The directed scenarios cover these by sending whole fields with the data line disturbed near every edge and comparing the strobed outputs with values worked out from the requirements.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

    localparam int LC_W    = 11;  // serial word length
    localparam int NUM_FMT = 7;

    typedef enum logic [2:0] {
        FMT_UNKNOWN = 3'd0,
        FMT_SD525I  = 3'd1,
        FMT_SD625I  = 3'd2,
        FMT_ED480P  = 3'd3,
        FMT_ED576P  = 3'd4,
        FMT_HD720P  = 3'd5,
        FMT_HD1080I = 3'd6,
        FMT_HD1080P = 3'd7
    } fmt_e;

    typedef struct packed {
        fmt_e fmt;
        logic field_one;
    } decode_t;

    // Larger nominal count per format slot
    function automatic int nominal_hi(input int idx);
        case (idx)
            0:       return 260;
            1:       return 310;
            2:       return 522;
            3:       return 622;
            4:       return 747;
            5:       return 560;
            default: return 1122;
        endcase
    endfunction

    function automatic logic is_interlaced(input int idx);
        return (idx == 0) || (idx == 1) || (idx == 5);
    endfunction

    function automatic fmt_e code_of(input int idx);
        case (idx)
            0:       return FMT_SD525I;
            1:       return FMT_SD625I;
            2:       return FMT_ED480P;
            3:       return FMT_ED576P;
            4:       return FMT_HD720P;
            5:       return FMT_HD1080I;
            default: return FMT_HD1080P;
        endcase
    endfunction

    function automatic decode_t classify(input logic [LC_W-1:0] cnt, input int tol);
        decode_t res;
        int      c;
        int      hi;
        int      lo;
        c             = int'(cnt);
        res.fmt       = FMT_UNKNOWN;
        res.field_one = 1'b1;
        for (int i = 0; i < NUM_FMT; i++) begin
            hi = nominal_hi(i);
            lo = is_interlaced(i) ? hi - 1 : hi;
            if ((c >= lo - tol) && (c <= hi + tol)) begin
                res.fmt       = code_of(i);
                res.field_one = !is_interlaced(i) || (c >= hi);
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/lcd_sync_edges.sv
module lcd_sync_edges (
    input  logic clk,
    input  logic rst,
    input  logic hsync_n,
    input  logic vsync_n,
    output logic h_fall,
    output logic v_fall
);
    logic h_q;
    logic v_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q <= 1'b1;
            v_q <= 1'b1;
        end else begin
            h_q <= hsync_n;
            v_q <= vsync_n;
        end
    end

    assign h_fall = h_q & ~hsync_n;
    assign v_fall = v_q & ~vsync_n;
endmodule

// File: rtl/lcd_midline_timer.sv
module lcd_midline_timer #(
    parameter int PER_W = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic h_fall,
    output logic mid_strobe
);
    localparam logic [PER_W-1:0] PER_MAX = {PER_W{1'b1}};

    logic [PER_W-1:0] per_cnt;
    logic [PER_W-1:0] mid_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            per_cnt <= '0;
            mid_cnt <= '0;
        end else if (h_fall) begin
            per_cnt <= '0;
            mid_cnt <= per_cnt >> 1;
        end else begin
            if (per_cnt != PER_MAX) per_cnt <= per_cnt + 1'b1;
            if (mid_cnt != '0)      mid_cnt <= mid_cnt - 1'b1;
        end
    end

    assign mid_strobe = (mid_cnt == PER_W'(1));

    AST_ONE_SAMPLE_PER_LINE: assert property (@(posedge clk) disable iff (rst)
        (mid_strobe && !h_fall) |=> !mid_strobe); // R2
endmodule

// File: rtl/lcd_bit_capture.sv
module lcd_bit_capture
    import lcd_pkg::*;
#(
    parameter int FIRST_EDGE = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            h_fall,
    input  logic            v_fall,
    input  logic            mid_strobe,
    input  logic            sdata,
    output logic [LC_W-1:0] word,
    output logic            word_vld
);
    localparam int IDX_W = $clog2(FIRST_EDGE + LC_W + 1);
    localparam int BIT_W = $clog2(LC_W + 1);
    localparam logic [IDX_W-1:0] IDX_MAX   = {IDX_W{1'b1}};
    localparam logic [IDX_W-1:0] IDX_FIRST = IDX_W'(FIRST_EDGE);
    localparam logic [IDX_W-1:0] IDX_END   = IDX_W'(FIRST_EDGE + LC_W);
    localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(LC_W - 1);

    logic [IDX_W-1:0] edge_idx;
    logic [IDX_W-1:0] idx_nxt;
    logic [BIT_W-1:0] bits;
    logic [LC_W-1:0]  shreg;
    logic [LC_W-1:0]  sh_nxt;
    logic             armed;
    logic             take;
    logic             take_nxt;

    always_comb begin
        idx_nxt  = (edge_idx == IDX_MAX) ? edge_idx : edge_idx + 1'b1;
        take_nxt = armed && (idx_nxt >= IDX_FIRST) && (idx_nxt < IDX_END);
        sh_nxt   = {shreg[LC_W-2:0], sdata};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_idx <= '0;
            bits     <= '0;
            shreg    <= '0;
            armed    <= 1'b0;
            take     <= 1'b0;
            word     <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            if (v_fall) begin
                edge_idx <= '0;
                bits     <= '0;
                armed    <= 1'b1;
                take     <= 1'b0;
            end else begin
                if (mid_strobe && take) begin
                    shreg <= sh_nxt;
                    take  <= 1'b0;
                    if (bits == BIT_LAST) begin
                        bits     <= '0;
                        armed    <= 1'b0;
                        word     <= sh_nxt;
                        word_vld <= 1'b1;
                    end else begin
                        bits <= bits + 1'b1;
                    end
                end
                if (h_fall) begin
                    edge_idx <= idx_nxt;
                    take     <= take_nxt;
                end
            end
        end
    end

    AST_BITS_BOUND: assert property (@(posedge clk) disable iff (rst)
        bits <= BIT_LAST); // R1
endmodule

// File: rtl/lcd_classifier.sv
module lcd_classifier
    import lcd_pkg::*;
#(
    parameter int TOL = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [LC_W-1:0] word,
    input  logic            word_vld,
    output logic [LC_W-1:0] line_count,
    output fmt_e            fmt_code,
    output logic            field_one,
    output logic            count_valid,
    output logic            composite
);
    localparam int COMP_BIT = LC_W - 3;  // third bit sent, MSB first

    decode_t dec;
    fmt_e    prev_cand;

    always_comb dec = classify(word, TOL);

    always_ff @(posedge clk) begin
        if (rst) begin
            line_count  <= '0;
            fmt_code    <= FMT_UNKNOWN;
            field_one   <= 1'b0;
            count_valid <= 1'b0;
            composite   <= 1'b0;
            prev_cand   <= FMT_UNKNOWN;
        end else begin
            count_valid <= word_vld;
            if (word_vld) begin
                line_count <= word;
                field_one  <= dec.field_one;
                composite  <= word[COMP_BIT];
                prev_cand  <= dec.fmt;
                if (dec.fmt == prev_cand) fmt_code <= dec.fmt;
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        count_valid |=> !count_valid); // R3

    AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !word_vld |=> $stable(fmt_code)); // R8

    AST_SD_IS_COMPOSITE: assert property (@(posedge clk) disable iff (rst)
        (count_valid && (fmt_code != $past(fmt_code)) &&
         ((fmt_code == FMT_SD525I) || (fmt_code == FMT_SD625I))) |-> composite); // R7
endmodule

// File: rtl/lcount_decoder.sv
module lcount_decoder
    import lcd_pkg::*;
#(
    parameter int PER_W      = 12,
    parameter int FIRST_EDGE = 3,
    parameter int TOL        = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hsync_n,
    input  logic            vsync_n,
    input  logic            vf_data,
    output logic [LC_W-1:0] line_count,
    output logic [2:0]      fmt_code,
    output logic            field_one,
    output logic            count_valid,
    output logic            composite
);
    logic            h_fall;
    logic            v_fall;
    logic            mid_strobe;
    logic [LC_W-1:0] word;
    logic            word_vld;
    fmt_e            fmt_q;

    lcd_sync_edges u_edges (
        .clk     (clk),
        .rst     (rst),
        .hsync_n (hsync_n),
        .vsync_n (vsync_n),
        .h_fall  (h_fall),
        .v_fall  (v_fall)
    );

    lcd_midline_timer #(.PER_W(PER_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .h_fall     (h_fall),
        .mid_strobe (mid_strobe)
    );

    lcd_bit_capture #(.FIRST_EDGE(FIRST_EDGE)) u_capture (
        .clk        (clk),
        .rst        (rst),
        .h_fall     (h_fall),
        .v_fall     (v_fall),
        .mid_strobe (mid_strobe),
        .sdata      (vf_data),
        .word       (word),
        .word_vld   (word_vld)
    );

    lcd_classifier #(.TOL(TOL)) u_class (
        .clk         (clk),
        .rst         (rst),
        .word        (word),
        .word_vld    (word_vld),
        .line_count  (line_count),
        .fmt_code    (fmt_q),
        .field_one   (field_one),
        .count_valid (count_valid),
        .composite   (composite)
    );

    assign fmt_code = fmt_q;
endmodule

// File: tb/tb_lcount_decoder.sv
module tb_lcount_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int LINE       = 64;
    localparam int HS_LEN     = 6;
    localparam int EDGE_JUNK  = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hsync_n = 1'b1;
    logic        vsync_n = 1'b1;
    logic        vf_data = 1'b0;
    logic [10:0] line_count;
    logic [2:0]  fmt_code;
    logic        field_one;
    logic        count_valid;
    logic        composite;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // monitor of strobed outputs
    int          mon_n = 0;
    bit          mon_wide = 1'b0;
    bit          prev_vld = 1'b0;
    logic [10:0] mon_cnt;
    logic [2:0]  mon_fmt;
    logic        mon_f1;
    logic        mon_comp;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcount_decoder dut (
        .clk         (clk),
        .rst         (rst),
        .hsync_n     (hsync_n),
        .vsync_n     (vsync_n),
        .vf_data     (vf_data),
        .line_count  (line_count),
        .fmt_code    (fmt_code),
        .field_one   (field_one),
        .count_valid (count_valid),
        .composite   (composite)
    );

    always @(negedge clk) begin
        if (count_valid) begin
            mon_n++;
            mon_cnt  = line_count;
            mon_fmt  = fmt_code;
            mon_f1   = field_one;
            mon_comp = composite;
            if (prev_vld) mon_wide = 1'b1;
        end
        prev_vld = count_valid;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one line; data wrong near both edges, correct mid-line
    task automatic do_line(input logic b, input bit vfall, input bit vrise);
        for (int c = 0; c < LINE; c++) begin
            hsync_n = (c < HS_LEN) ? 1'b0 : 1'b1;
            vf_data = (c < EDGE_JUNK || c >= LINE - EDGE_JUNK) ? ~b : b;
            if (c == LINE/2 && vfall) vsync_n = 1'b0;
            if (c == LINE/2 && vrise) vsync_n = 1'b1;
            @(negedge clk);
        end
    endtask

    // nlines lines after the vsync-fall line; bits ride edges 3..13
    task automatic send_field(input logic [10:0] v, input int nlines);
        for (int l = 0; l < nlines; l++) begin
            logic b;
            b = (l >= 3 && l <= 13) ? v[13-l] : 1'b1;
            do_line(b, l == 0, l == 3);
        end
    endtask

    task automatic field_and_check(input logic [10:0] v, input int exp_fmt, input bit exp_f1);
        mon_n = 0;
        mon_wide = 1'b0;
        send_field(v, 16);
        chk(mon_n == 1, "R3 one count_valid per field", mon_n, 1);
        chk(!mon_wide, "R3 count_valid single cycle", int'(mon_wide), 0);
        chk(mon_cnt == v, "R1 R2 received count", int'(mon_cnt), int'(v));
        chk(mon_fmt == 3'(exp_fmt), "R4 R5 R8 fmt_code", int'(mon_fmt), exp_fmt);
        chk(mon_f1 == exp_f1, "R6 field_one", int'(mon_f1), int'(exp_f1));
        chk(mon_comp == v[8], "R7 composite", int'(mon_comp), int'(v[8]));
    endtask

    task automatic test_reset();
        repeat (4) @(negedge clk);
        chk(line_count == 11'd0, "R9 line_count at reset", int'(line_count), 0);
        chk(fmt_code == 3'd0, "R9 fmt_code at reset", int'(fmt_code), 0);
        chk(field_one == 1'b0, "R9 field_one at reset", int'(field_one), 0);
        chk(count_valid == 1'b0, "R9 count_valid at reset", int'(count_valid), 0);
        chk(composite == 1'b0, "R9 composite at reset", int'(composite), 0);
        rst = 1'b0;
        for (int i = 0; i < 3; i++) do_line(1'b0, 1'b0, 1'b0);
    endtask

    task automatic test_sd_pairs();
        field_and_check(11'd260, 0, 1'b1);  // R8 not yet confirmed
        field_and_check(11'd259, 1, 1'b0);  // R4 525i confirmed, field 2
        field_and_check(11'd522, 1, 1'b1);  // R8 hold old code
        field_and_check(11'd522, 3, 1'b1);
        field_and_check(11'd310, 3, 1'b1);
        field_and_check(11'd309, 2, 1'b0);
    endtask

    task automatic test_hd_and_tolerance();
        field_and_check(11'd622, 2, 1'b1);
        field_and_check(11'd624, 4, 1'b1);  // R4 +2 tolerance
        field_and_check(11'd560, 4, 1'b1);
        field_and_check(11'd559, 6, 1'b0);
        field_and_check(11'd1122, 6, 1'b1);
        field_and_check(11'd1122, 7, 1'b1);
        field_and_check(11'd749, 7, 1'b1);
        field_and_check(11'd745, 5, 1'b1);  // R4 -2 tolerance
    endtask

    task automatic test_unknown();
        field_and_check(11'd750, 5, 1'b1);  // R5 out of window, held
        field_and_check(11'd750, 0, 1'b1);  // R5 unknown confirmed
    endtask

    task automatic test_restart();
        mon_n = 0;
        send_field(11'd1122, 8);            // aborted after 5 bits
        chk(mon_n == 0, "R1 aborted capture gives no strobe", mon_n, 0);
        field_and_check(11'd310, 0, 1'b1);  // R1 restart yields clean word
        field_and_check(11'd309, 2, 1'b0);
    endtask

    initial begin
        test_reset();
        test_sd_pairs();
        test_hd_and_tolerance();
        test_unknown();
        test_restart();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule